// File: doc/BRIEF.md
# Baud Divider with Register Front End

This block is the clock-division and register-steering core of a 16550-class UART. A reference clock is divided by a 16-bit divisor. The divisor is kept in two byte-wide latches, and the block emits a single-cycle enable at sixteen times the baud rate. The transmit and receive shifters use that enable as their sampling strobe. The serial shifters and FIFOs sit outside this block. It only passes through their data and access strobes.

A host writes a line control register. Bit 7 of that register selects what the two lowest addresses reach. When the bit is set, they reach the divisor bytes. When it is clear, they reach the receive/transmit data port and the interrupt enable register. A write to either divisor byte reloads the running counter immediately, so a new rate takes effect from the next clock. A divisor of zero is unsupported, and it leaves the enable quiet.

Top module: `uart_baud_core`

## Requirements
- R1: After reset, the line control register reads 0x00, the interrupt enable register reads 0x00, both divisor bytes read 0x00 and the baud enable is low.
- R2: Address 3 holds an 8-bit line control register that reads back what was written and is driven on `lcr_o`. Its bit 7 is the divisor access bit.
- R3: With the access bit at 1, address 0 reads and writes the low divisor byte and address 1 the high divisor byte. `tx_wr_o` and `rx_rd_o` stay low for such accesses.
- R4: With the access bit at 0, a write to address 0 pulses `tx_wr_o` with `tx_data_o` equal to the written byte. A read of address 0 returns `rx_data_i` and pulses `rx_rd_o`. Address 1 reads and writes the 8-bit interrupt enable register, which is driven on `ier_o`.
- R5: For a divisor N ≥ 2, the enable is high for exactly one cycle in every N cycles.
- R6: A write to either divisor byte reloads the counter with the resulting 16-bit divisor. The first enable then appears in the Nth cycle after the write edge. This holds for a write of the high byte alone.
- R7: A divisor of 1 gives an enable on every clock cycle.
- R8: A divisor of 0 holds the enable low.
- R9: A divisor write that falls in the same cycle as a terminal-count enable takes precedence over the automatic reload. The next enable follows the new divisor.
- R10: Writes to addresses 0 and 1 with the access bit at 0 leave both divisor bytes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the addressed register |
| rx_data_i | input | 8 | Byte presented by the receive path |
| rx_rd_o | output | 1 | Receive data consumed |
| tx_data_o | output | 8 | Byte for the transmit path |
| tx_wr_o | output | 1 | Transmit data strobe |
| ier_o | output | 8 | Interrupt enable register contents |
| lcr_o | output | 8 | Line control register contents |
| baud16_tick_o | output | 1 | One-cycle enable at 16x baud rate |

## Verification
A divisor write can land in the very cycle where the counter reaches its terminal count. In that cycle both the immediate reload and the automatic reload want the counter. The bench provokes this by waiting for a visible enable, then issuing a low-byte write in that same cycle. It passes only if the following enables are spaced by the newly written divisor and not the old one. Random divisors and a lone high-byte write check that the reload value is always the full 16-bit combination of both bytes.

// File: rtl/uart_baud_pkg.sv
package uart_baud_pkg;
  localparam int unsigned A_DATA = 0;
  localparam int unsigned A_IER  = 1;
  localparam int unsigned A_LCR  = 3;
  localparam int unsigned DLAB_BIT = 7;

  typedef struct packed {
    logic [1:0] div;   // [0] low byte, [1] high byte
    logic       data;  // rx read / tx write port
    logic       ier;
    logic       lcr;
  } sel_t;
endpackage

// File: rtl/uart_baud_decode.sv
module uart_baud_decode
  import uart_baud_pkg::*;
#(
  parameter int unsigned ADDR_W = 3
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              dlab_i,
  output sel_t              sel_o
);
  always_comb begin
    sel_o        = '0;
    sel_o.div[0] = dlab_i  && (addr_i == ADDR_W'(A_DATA));
    sel_o.div[1] = dlab_i  && (addr_i == ADDR_W'(A_IER));
    sel_o.data   = !dlab_i && (addr_i == ADDR_W'(A_DATA));
    sel_o.ier    = !dlab_i && (addr_i == ADDR_W'(A_IER));
    sel_o.lcr    = (addr_i == ADDR_W'(A_LCR));
  end

  // R3 R4
  always_comb begin
    sel_onehot_chk: assert ($onehot0(sel_o));
  end
endmodule

// File: rtl/uart_baud_counter.sv
module uart_baud_counter #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [DIV_W-1:0] load_val_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (load_i)              cnt_q <= load_val_i;  // write beats terminal reload
    else if (div_i == '0)         cnt_q <= '0;          // park on unsupported divisor
    else if (cnt_q <= DIV_W'(1))  cnt_q <= div_i;
    else                          cnt_q <= cnt_q - DIV_W'(1);
  end

  assign tick_o = (cnt_q == DIV_W'(1));

  // R6
  reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(load_val_i));
  // R5
  step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && div_i != '0 && cnt_q > DIV_W'(1)) |=> cnt_q == $past(cnt_q) - DIV_W'(1));
  // R5
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && tick_o) |=> cnt_q == $past(div_i));
  // R8
  zero_div_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_i == '0) |-> !tick_o);
  // R7
  div_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && div_i == DIV_W'(1)) |=> tick_o);
endmodule

// File: rtl/uart_baud_core.sv
module uart_baud_core
  import uart_baud_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [DATA_W-1:0] rx_data_i,
  output logic              rx_rd_o,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              tx_wr_o,
  output logic [DATA_W-1:0] ier_o,
  output logic [DATA_W-1:0] lcr_o,
  output logic              baud16_tick_o
);
  localparam int unsigned DIV_BYTES = 2;
  localparam int unsigned DIV_W     = DIV_BYTES * DATA_W;

  sel_t                                 sel;
  logic [DATA_W-1:0]                    lcr_q, ier_q;
  logic [DIV_BYTES-1:0][DATA_W-1:0]     div_q, div_nxt;
  logic                                 div_load;

  uart_baud_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr_i (addr_i),
    .dlab_i (lcr_q[DLAB_BIT]),
    .sel_o  (sel)
  );

  always_comb begin
    div_nxt = div_q;
    for (int b = 0; b < DIV_BYTES; b++)
      if (wr_i && sel.div[b]) div_nxt[b] = wdata_i;
  end
  assign div_load = wr_i && (|sel.div);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lcr_q <= '0;
      ier_q <= '0;
      div_q <= '0;
    end else begin
      div_q <= div_nxt;
      if (wr_i && sel.lcr) lcr_q <= wdata_i;
      if (wr_i && sel.ier) ier_q <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int b = 0; b < DIV_BYTES; b++)
      if (sel.div[b]) rdata_o = div_q[b];
    if (sel.data) rdata_o = rx_data_i;
    if (sel.ier)  rdata_o = ier_q;
    if (sel.lcr)  rdata_o = lcr_q;
  end

  assign rx_rd_o   = rd_i && sel.data;
  assign tx_wr_o   = wr_i && sel.data;
  assign tx_data_o = wdata_i;
  assign ier_o     = ier_q;
  assign lcr_o     = lcr_q;

  uart_baud_counter #(.DIV_W(DIV_W)) u_counter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (div_load),
    .load_val_i (div_nxt),
    .div_i      (div_q),
    .tick_o     (baud16_tick_o)
  );

  // R3
  no_port_in_dlab_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lcr_q[DLAB_BIT] |-> (!tx_wr_o && !rx_rd_o));
  // R10
  div_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && lcr_q[DLAB_BIT] && addr_i < ADDR_W'(2)) |=> $stable(div_q));
endmodule

// File: tb/uart_baud_core_tb.sv
module uart_baud_core_tb;
  logic       clk = 0;
  logic       rst_ni = 0;
  logic [2:0] addr_i = '0;
  logic       wr_i = 0, rd_i = 0;
  logic [7:0] wdata_i = '0, rx_data_i = '0;
  logic [7:0] rdata_o, tx_data_o, ier_o, lcr_o;
  logic       rx_rd_o, tx_wr_o, tick;
  int         total = 0, bad = 0;
  logic [7:0] rv;
  logic       st;

  always #5 clk = ~clk;

  uart_baud_core u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .rx_data_i(rx_data_i), .rx_rd_o(rx_rd_o),
    .tx_data_o(tx_data_o), .tx_wr_o(tx_wr_o), .ier_o(ier_o), .lcr_o(lcr_o),
    .baud16_tick_o(tick)
  );

  function automatic int exp_first(int n); return n - 1; endfunction
  function automatic int exp_gap(int n);   return n;     endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    addr_i = a; wdata_i = d; wr_i = 1;
    @(posedge clk); @(negedge clk);
    wr_i = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d, output logic s);
    addr_i = a; rd_i = 1;
    #1 d = rdata_o; s = rx_rd_o;
    @(posedge clk); @(negedge clk);
    rd_i = 0;
  endtask

  task automatic program_div(int n);
    wr(3'd3, 8'h80);
    wr(3'd1, n[15:8]);
    wr(3'd0, n[7:0]);
  endtask

  task automatic measure(int n, string req);
    int first = -1, second = -1;
    for (int i = 0; i < 2 * n + 4; i++) begin
      if (tick) begin
        if (first < 0) first = i;
        else if (second < 0) second = i;
      end
      @(negedge clk);
    end
    chk(first == exp_first(n), req, first, exp_first(n));
    chk(second - first == exp_gap(n), req, second - first, exp_gap(n));
  endtask

  task automatic summary;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=0 exp=1");
    summary();
  end

  initial begin
    int seed = 32'h5a17;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);

    // R1 reset state
    rd(3'd3, rv, st); chk(rv == 8'h00, "R1 lcr", rv, 0);
    rd(3'd1, rv, st); chk(rv == 8'h00, "R1 ier", rv, 0);
    begin
      int seen = 0;
      for (int i = 0; i < 20; i++) begin if (tick) seen++; @(negedge clk); end
      chk(seen == 0, "R1 tick", seen, 0);
    end
    wr(3'd3, 8'h80);
    rd(3'd0, rv, st); chk(rv == 8'h00, "R1 dll", rv, 0);
    rd(3'd1, rv, st); chk(rv == 8'h00, "R1 dlm", rv, 0);

    // R2 line control readback
    for (int i = 0; i < 4; i++) begin
      logic [7:0] x = 8'($urandom);
      wr(3'd3, x);
      rd(3'd3, rv, st); chk(rv == x, "R2 rd", rv, x);
      chk(lcr_o == x, "R2 port", lcr_o, x);
    end

    // R7 R5 R6 directed divisors
    program_div(1);   measure(1, "R7");
    program_div(2);   measure(2, "R5");
    program_div(259); measure(259, "R6 both");
    program_div(3);
    wr(3'd1, 8'h01);  measure(259, "R6 hi only");

    // R5 random divisors
    for (int i = 0; i < 8; i++) begin
      int n = 1 + int'($urandom_range(39));
      program_div(n); measure(n, "R5 rand");
    end

    // R9 write in terminal-count cycle
    program_div(6);
    while (!tick) @(negedge clk);
    wr(3'd0, 8'd9);
    measure(9, "R9");

    // R8 zero divisor
    program_div(0);
    begin
      int seen = 0;
      for (int i = 0; i < 60; i++) begin if (tick) seen++; @(negedge clk); end
      chk(seen == 0, "R8", seen, 0);
    end

    // R3 divisor readback, no port strobes
    program_div(16'h2a07);
    rd(3'd0, rv, st); chk(rv == 8'h07, "R3 dll", rv, 8'h07);
    chk(st == 0, "R3 no rx_rd", st, 0);
    rd(3'd1, rv, st); chk(rv == 8'h2a, "R3 dlm", rv, 8'h2a);
    addr_i = 3'd0; wdata_i = 8'h07; wr_i = 1;
    #1 chk(tx_wr_o == 0, "R3 no tx_wr", tx_wr_o, 0);
    @(posedge clk); @(negedge clk); wr_i = 0;

    // R4 data port and interrupt enable
    wr(3'd3, 8'h03);
    for (int i = 0; i < 3; i++) begin
      logic [7:0] d = 8'($urandom);
      logic [7:0] e = 8'($urandom);
      logic [7:0] r = 8'($urandom);
      addr_i = 3'd0; wdata_i = d; wr_i = 1;
      #1 chk(tx_wr_o == 1, "R4 tx_wr", tx_wr_o, 1);
      chk(tx_data_o == d, "R4 tx_data", tx_data_o, d);
      @(posedge clk); @(negedge clk); wr_i = 0;
      wr(3'd1, e);
      rd(3'd1, rv, st); chk(rv == e, "R4 ier rd", rv, e);
      chk(ier_o == e, "R4 ier port", ier_o, e);
      rx_data_i = r;
      rd(3'd0, rv, st); chk(rv == r, "R4 rx data", rv, r);
      chk(st == 1, "R4 rx_rd", st, 1);
    end

    // R10 divisor untouched by data-side writes
    wr(3'd3, 8'h80);
    rd(3'd0, rv, st); chk(rv == 8'h07, "R10 dll", rv, 8'h07);
    rd(3'd1, rv, st); chk(rv == 8'h2a, "R10 dlm", rv, 8'h2a);

    summary();
  end
endmodule